// File: doc/BRIEF.md
# 3x3 Valid-Window Convolution Engine

This block filters a single image with a 3x3 kernel and produces only the output positions whose window lies entirely inside the image. Pixels arrive one per handshake in raster order: left to right along a row, then row after row. The engine stores the two rows above the current one in line memories and keeps the two most recent columns of the window in registers. With every accepted pixel it forms the window that ends at that pixel, multiplies its nine samples by nine signed weights, adds the products together and adds a bias. The result leaves through a registered valid/ready output that also carries end-of-row and end-of-frame flags.

Software loads the weights, the bias and the image size through a small write port between frames. An image of W columns and H rows gives an output of (W-2) columns by (H-2) rows, because the one-pixel border is lost. A stalled output holds back the input, so no pixel is lost and no result is overwritten.

Top module: `conv3x3_valid_engine`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A frame of W by H input pixels gives exactly (W-2)*(H-2) results in raster order. No window that runs past the image edge produces a result.
- R3: Each result equals the sum over r,c in 0..2 of weight[3*r+c] times pixel(y-2+r, x-2+c), plus the bias. Here (x,y) is the position of the pixel that completes the window, and r=0 is the oldest row. Config addresses 0..8 write weight k from cfg_wdata[7:0], treated as a signed 8-bit value.
- R4: Config address 9 writes the bias from cfg_wdata[15:0], treated as a signed 16-bit value. It is sign-extended to the 20-bit result width before it is added.
- R5: out_eol is 1 on the last result of each output row. out_eof is 1 only on the last result of the frame, and out_eol is also 1 on that result.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_data, out_eol and out_eof stay unchanged.
- R7: A config write that arrives while a frame is in progress is ignored. A frame is in progress from its first accepted pixel until its last accepted pixel, and the write is ignored even on that last pixel's cycle.
- R8: Config address 10 sets the width and address 11 sets the height, both from cfg_wdata. A value below 3 or above the synthesis maximum (default 64) is ignored.
- R9: The first result of a frame becomes valid in the cycle after the frame's (2*W+3)-th pixel is accepted. Every later result becomes valid in the cycle after the pixel that completes its window is accepted.
- R10: Frames may follow one another with no gap and no extra control. The position counters return to the frame start after the last pixel, and the same configuration stays in use.
- R11: No intermediate value overflows, even with all-extreme pixels and weights (-128) and an extreme bias in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config address: 0..8 weight, 9 bias, 10 width, 11 height |
| cfg_wdata | input | 16 | Config write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Engine can take a pixel |
| in_pixel | input | 8 | Signed input pixel |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 20 | Signed filtered value |
| out_eol | output | 1 | Last result of an output row |
| out_eof | output | 1 | Last result of the frame |

## Verification
The assertions assume that configuration changes only between frames. They also assume that width and height are fixed for the whole frame, so that the position counters and the stored dimensions agree at every end-of-frame result. The bench writes the kernel and the image size only when no frame is in flight. The one exception is a deliberate mid-frame write, which the engine must discard; checking that requires no assumption. The output handshake is driven with several ready patterns, including long stalls. Every result is compared against a scoreboard that computes its own expected values.

// File: rtl/conv3x3_pkg.sv
package conv3x3_pkg;
  parameter int unsigned PIX_W  = 8;
  parameter int unsigned COEF_W = 8;
  parameter int unsigned BIAS_W = 16;
  parameter int unsigned ACC_W  = 20;
  parameter int unsigned KDIM   = 3;
  parameter int unsigned CFG_AW = 4;
  parameter int unsigned CFG_DW = 16;
  localparam int unsigned NTAPS     = KDIM * KDIM;
  localparam int unsigned ADDR_BIAS = NTAPS;
  localparam int unsigned ADDR_WID  = NTAPS + 1;
  localparam int unsigned ADDR_HGT  = NTAPS + 2;
  localparam int unsigned MIN_DIM   = KDIM;

  typedef logic signed [PIX_W-1:0]  pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [BIAS_W-1:0] bias_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef pix_t  [NTAPS-1:0] taps_t;
  typedef coef_t [NTAPS-1:0] coefs_t;
  typedef pix_t  [KDIM-1:0]  column_t;

  // one widened product of a window sample and its weight
  function automatic acc_t tap_product(input pix_t p, input coef_t w);
    return acc_t'(p) * acc_t'(w);
  endfunction

  // nine-tap dot product plus sign-extended bias
  function automatic acc_t conv_dot9(input taps_t taps, input coefs_t w, input bias_t b);
    acc_t s;
    s = acc_t'(b);
    for (int k = 0; k < NTAPS; k++) begin
      s = s + tap_product(taps[k], w[k]);
    end
    return s;
  endfunction

  // legal image dimension for a given upper bound
  function automatic logic dim_legal(input logic [CFG_DW-1:0] v, input int unsigned maxv);
    return (32'(v) >= MIN_DIM) && (32'(v) <= maxv);
  endfunction
endpackage

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs import conv3x3_pkg::*; #(
  parameter int unsigned MAX_W = 64,
  parameter int unsigned MAX_H = 64,
  parameter int unsigned DW_W  = $clog2(MAX_W + 1),
  parameter int unsigned DW_H  = $clog2(MAX_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic              frame_busy,
  output coefs_t            coefs,
  output bias_t             bias,
  output logic [DW_W-1:0]   img_w,
  output logic [DW_H-1:0]   img_h
);
  // a write is taken only between frames
  logic  wr_take;
  coef_t coef_q [NTAPS];
  bias_t bias_q;
  logic [DW_W-1:0] wid_q;
  logic [DW_H-1:0] hgt_q;

  assign wr_take = wr_en && !frame_busy;

  for (genvar k = 0; k < NTAPS; k++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coef_q[k] <= '0;
      end else if (wr_take && (32'(wr_addr) == k)) begin
        coef_q[k] <= coef_t'(wr_data[COEF_W-1:0]);
      end
    end
    assign coefs[k] = coef_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_q <= '0;
      wid_q  <= DW_W'(MAX_W);
      hgt_q  <= DW_H'(MAX_H);
    end else if (wr_take) begin
      if (32'(wr_addr) == ADDR_BIAS) bias_q <= bias_t'(wr_data[BIAS_W-1:0]);
      if (32'(wr_addr) == ADDR_WID && dim_legal(wr_data, MAX_W)) wid_q <= wr_data[DW_W-1:0];
      if (32'(wr_addr) == ADDR_HGT && dim_legal(wr_data, MAX_H)) hgt_q <= wr_data[DW_H-1:0];
    end
  end

  assign bias  = bias_q;
  assign img_w = wid_q;
  assign img_h = hgt_q;

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy |=> ($stable(coefs) && $stable(bias_q) && $stable(wid_q) && $stable(hgt_q)));

  assert_dims_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wid_q) >= MIN_DIM) && (32'(wid_q) <= MAX_W) &&
    (32'(hgt_q) >= MIN_DIM) && (32'(hgt_q) <= MAX_H));
endmodule

// File: rtl/conv_line_store.sv
module conv_line_store #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read the old row's sample before it is replaced
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= din;
  end
endmodule

// File: rtl/conv_window.sv
module conv_window import conv3x3_pkg::*; (
  input  logic    clk,
  input  logic    shift_en,
  input  column_t new_col,
  output taps_t   taps
);
  // two older columns per row; the newest column comes straight from the input
  pix_t hist [KDIM][KDIM-1];

  always_ff @(posedge clk) begin
    if (shift_en) begin
      for (int r = 0; r < KDIM; r++) begin
        for (int c = 0; c < KDIM - 2; c++) begin
          hist[r][c] <= hist[r][c+1];
        end
        hist[r][KDIM-2] <= new_col[r];
      end
    end
  end

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    for (genvar c = 0; c < KDIM; c++) begin : g_col
      if (c == KDIM - 1) begin : g_new
        assign taps[r*KDIM + c] = new_col[r];
      end else begin : g_old
        assign taps[r*KDIM + c] = hist[r][c];
      end
    end
  end
endmodule

// File: rtl/conv3x3_valid_engine.sv
module conv3x3_valid_engine import conv3x3_pkg::*; #(
  parameter int unsigned MAX_W = 64,
  parameter int unsigned MAX_H = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pixel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data,
  output logic              out_eol,
  output logic              out_eof
);
  localparam int unsigned DW_W  = $clog2(MAX_W + 1);
  localparam int unsigned DW_H  = $clog2(MAX_H + 1);
  localparam int unsigned LB_AW = $clog2(MAX_W);

  // configuration
  coefs_t          coefs;
  bias_t           bias;
  logic [DW_W-1:0] img_w;
  logic [DW_H-1:0] img_h;

  // position and events
  logic [DW_W-1:0] col_q;
  logic [DW_H-1:0] row_q;
  logic acc_fire, emit_now, out_fire, col_last, row_last, frame_busy, win_full;

  // data path
  logic [PIX_W-1:0] chain [KDIM];
  column_t new_col;
  taps_t   taps;
  acc_t    sum_val;

  // output register
  logic out_valid_q, out_eol_q, out_eof_q;
  acc_t out_data_q;

  assign in_ready   = !out_valid_q || out_ready;
  assign acc_fire   = in_valid && in_ready;
  assign out_fire   = out_valid_q && out_ready;
  assign col_last   = (col_q == img_w - DW_W'(1));
  assign row_last   = (row_q == img_h - DW_H'(1));
  assign frame_busy = (col_q != '0) || (row_q != '0);
  assign win_full   = (col_q >= DW_W'(KDIM - 1)) && (row_q >= DW_H'(KDIM - 1));
  assign emit_now   = acc_fire && win_full;

  conv_cfg_regs #(.MAX_W(MAX_W), .MAX_H(MAX_H), .DW_W(DW_W), .DW_H(DW_H)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .frame_busy (frame_busy),
    .coefs      (coefs),
    .bias       (bias),
    .img_w      (img_w),
    .img_h      (img_h)
  );

  // raster position
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (acc_fire) begin
      if (col_last) begin
        col_q <= '0;
        row_q <= row_last ? '0 : row_q + DW_H'(1);
      end else begin
        col_q <= col_q + DW_W'(1);
      end
    end
  end

  // line stores: chain[1] is one row up, chain[2] is two rows up
  assign chain[0] = in_pixel;
  for (genvar s = 0; s < KDIM - 1; s++) begin : g_line
    conv_line_store #(.DEPTH(MAX_W), .DATA_W(PIX_W), .AW(LB_AW)) u_store (
      .clk   (clk),
      .wr_en (acc_fire),
      .addr  (col_q[LB_AW-1:0]),
      .din   (chain[s]),
      .dout  (chain[s+1])
    );
  end

  // newest window column, oldest row first
  for (genvar r = 0; r < KDIM; r++) begin : g_newcol
    assign new_col[r] = pix_t'(chain[KDIM-1-r]);
  end

  conv_window u_win (
    .clk      (clk),
    .shift_en (acc_fire),
    .new_col  (new_col),
    .taps     (taps)
  );

  assign sum_val = conv_dot9(taps, coefs, bias);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_eol_q   <= 1'b0;
      out_eof_q   <= 1'b0;
    end else if (emit_now) begin
      out_valid_q <= 1'b1;
      out_data_q  <= sum_val;
      out_eol_q   <= col_last;
      out_eof_q   <= col_last && row_last;
    end else if (out_fire) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_eol   = out_eol_q;
  assign out_eof   = out_eof_q;

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eol) && $stable(out_eof)));

  assert_eof_ends_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> out_eol);

  assert_frame_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> !frame_busy);

  assert_emit_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_fire));
endmodule

// File: tb/conv3x3_valid_engine_tb_top.sv
`timescale 1ns/1ps
module conv3x3_valid_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_pixel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_data;
  logic        out_eol, out_eof;

  always #2.5 clk = ~clk;

  conv3x3_valid_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_eol(out_eol), .out_eof(out_eof)
  );

  typedef struct { int data; bit eol; bit eof; string tag; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  int w_m[9];
  int b_m = 0, wid_m = 64, hgt_m = 64;
  int img[16][16];
  string cur_tag = "R3";
  int rdy_mode = 0, cyc = 0;
  int hs_cnt = 0, out_cnt = 0;
  bit watch_first = 0;
  int first_w = 0;
  bit prev_stall = 0;
  int prev_data = 0;
  bit prev_eol = 0, prev_eof = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // output ready patterns
  always @(posedge clk) begin
    #1;
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 1;
      default: out_ready = (cyc % 7) < 2;
    endcase
  end

  // monitor: sample mid-cycle, the handshake happens at the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid == 1'b1 && $signed(out_data) == prev_data && out_eol == prev_eol && out_eof == prev_eof,
              "R6", "held output", $signed(out_data), prev_data);
      end
      if (out_valid && !out_ready) begin
        check(in_ready == 1'b0, "R6", "in_ready during stall", int'(in_ready), 0);
      end
      if (out_valid && watch_first) begin
        check(hs_cnt == 2 * first_w + 3, "R9", "pixels before first result", hs_cnt, 2 * first_w + 3);
        watch_first = 0;
      end
      if (out_valid && out_ready) begin
        out_cnt++;
        if (sbq.size() == 0) begin
          check(0, "R2", "unexpected result", $signed(out_data), 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check($signed(out_data) == e.data, e.tag, "data", $signed(out_data), e.data);
          check(out_eol == e.eol && out_eof == e.eof, "R5", "eol/eof",
                int'({out_eol, out_eof}), int'({e.eol, e.eof}));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = $signed(out_data);
      prev_eol   = out_eol;
      prev_eof   = out_eof;
      if (in_valid && in_ready) hs_cnt++;
    end
  end

  task automatic cfg_write(input int a, input int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_kernel(input int base, input int step, input int bias);
    for (int k = 0; k < 9; k++) begin
      w_m[k] = base + step * k;
      if (w_m[k] > 127) w_m[k] = w_m[k] - 256;
      if (w_m[k] < -128) w_m[k] = w_m[k] + 256;
      cfg_write(k, w_m[k] & 8'hff);
    end
    b_m = bias;
    cfg_write(9, bias & 16'hffff);
  endtask

  task automatic set_dims(input int w, input int h);
    cfg_write(10, w); wid_m = w;
    cfg_write(11, h); hgt_m = h;
  endtask

  task automatic fill_image(input int seed);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++)
        img[y][x] = ((x * 37 + y * 11 + seed * 53 + x * y) % 256) - 128;
  endtask

  task automatic fill_const(input int v);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++)
        img[y][x] = v;
  endtask

  // scoreboard driver: expected results are queued, then the frame is sent
  task automatic send_frame();
    for (int y = 2; y < hgt_m; y++) begin
      for (int x = 2; x < wid_m; x++) begin
        exp_t e;
        int s;
        s = b_m;
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++)
            s += w_m[3 * r + c] * img[y - 2 + r][x - 2 + c];
        e.data = s; e.eol = (x == wid_m - 1); e.eof = e.eol && (y == hgt_m - 1); e.tag = cur_tag;
        sbq.push_back(e);
      end
    end
    @(posedge clk); #1;
    for (int y = 0; y < hgt_m; y++) begin
      for (int x = 0; x < wid_m; x++) begin
        in_valid = 1'b1;
        in_pixel = 8'(img[y][x]);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic drain(input int expect_cnt, input string tag);
    while (sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(out_cnt == expect_cnt, tag, "result count", out_cnt, expect_cnt);
    out_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R3 / R9 / R2: basic 5x5 with full ready
    set_kernel(1, 1, 5);
    set_dims(5, 5);
    fill_image(1);
    cur_tag = "R3"; hs_cnt = 0; first_w = 5; watch_first = 1;
    send_frame();
    drain(9, "R2");

    // R6: stalls with signed kernel and negative bias (R4)
    rdy_mode = 1;
    set_kernel(-7, 3, -1000);
    set_dims(8, 4);
    fill_image(2);
    cur_tag = "R4";
    send_frame();
    drain(12, "R2");

    // R11: extreme corners in both directions
    rdy_mode = 2;
    set_kernel(-128, 0, 32767);
    set_dims(4, 4);
    fill_const(-128);
    cur_tag = "R11";
    send_frame();
    drain(4, "R11");
    set_kernel(-128, 0, -32768);
    fill_const(127);
    send_frame();
    drain(4, "R11");

    // R8: illegal dimensions ignored, then minimum 3x3 frame
    rdy_mode = 0;
    set_kernel(2, -1, 3);
    set_dims(6, 5);
    cfg_write(10, 2);
    cfg_write(10, 65);
    cfg_write(11, 1);
    cfg_write(11, 200);
    fill_image(3);
    cur_tag = "R8";
    send_frame();
    drain(12, "R8");
    set_dims(3, 3);
    fill_image(4);
    cur_tag = "R5";
    send_frame();
    drain(1, "R5");

    // R7: writes during a frame are discarded
    set_dims(6, 6);
    fill_image(5);
    cur_tag = "R7";
    fork
      send_frame();
      begin
        repeat (10) @(posedge clk);
        cfg_write(0, 99);
        cfg_write(9, 1234);
        cfg_write(10, 4);
      end
    join
    drain(16, "R7");
    fill_image(6);
    send_frame();
    drain(16, "R7");

    // R10: back-to-back frames under stalls
    rdy_mode = 1;
    set_dims(7, 5);
    cur_tag = "R10";
    fill_image(7);
    send_frame();
    fill_image(8);
    send_frame();
    drain(30, "R10");

    summary();
  end
endmodule